// File: doc/BRIEF.md
# Phase Lock Detector with Watchdog Hysteresis

This block turns a stream of phase-error magnitude samples into a single, steady lock indication. A sample-valid strobe marks each sample, at most one per cycle of the divided sample clock. Each valid sample is compared against a programmable threshold, and the result is classed as good or bad. Two run-length watchdogs sit behind the comparator. The first is a qualification counter: it raises the lock flag once the run of consecutive good samples reaches a power of two set by a lock exponent. The second is a loss counter: once the flag is up, it drops the flag when the run of consecutive bad samples reaches a separate power of two set by an unlock exponent.

The two exponents are independent, so the hysteresis can be asymmetric. Lock can be slow to gain and quick to lose, or the other way round. After a loss, the detector goes back to qualification on its own, starting from zero. The settings are plain input ports.

Top module: `phase_lock_det`

## Requirements
- R1: A valid sample is good when its magnitude is strictly less than the threshold. A sample equal to or above the threshold is bad.
- R2: With lock exponent X, the lock flag rises in the cycle after the 2^X-th consecutive good valid sample, and not earlier.
- R3: A bad valid sample during qualification discards the good run, so a full new run of 2^X good samples is needed.
- R4: A lock exponent above the parameter X_MAX (default 20) behaves exactly as X_MAX.
- R5: Once raised, the flag stays high through bad runs shorter than 2^(Y+1) samples and through any number of cycles without a valid sample.
- R6: With unlock exponent Y, the flag falls in the cycle after the 2^(Y+1)-th consecutive bad valid sample seen while locked.
- R7: A good valid sample while locked discards the bad run counted so far.
- R8: After the flag falls, qualification restarts from zero and needs 2^X fresh good samples.
- R9: Cycles with the valid strobe low neither advance nor break either run, whatever the magnitude input holds.
- R10: Synchronous reset clears the flag and both runs. Reset wins over a sample that would complete qualification in the same cycle.
- R11: With X = 0, a single good valid sample raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Strobe marking a new sample |
| smp_mag_i | input | MAG_W | Phase-error magnitude of the sample |
| thr_i | input | MAG_W | Good/bad threshold |
| lock_exp_i | input | XW | Lock exponent X |
| unlock_exp_i | input | YW | Unlock exponent Y |
| locked_o | output | 1 | Sticky lock flag |

## Verification
Two events can land in one clock edge. The first is the final good sample that completes qualification. The second is a synchronous reset. The bench drives a sample that would finish a 2^1 run in the same cycle as the reset pulse, then checks two things: the flag stays low, and two more good samples are still needed. A second coincidence also gets attention. On the edge where unlock is declared, the qualification run must start from zero, so the bench checks that re-lock takes the full 2^X samples after the flag falls.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

   // Limit a requested exponent to the largest supported value.
   function automatic int unsigned clamp_exp(input int unsigned req, input int unsigned lim);
      return (req > lim) ? lim : req;
   endfunction

endpackage

// File: rtl/lockdet_cmp.sv
module lockdet_cmp #(
   parameter int MAG_W = 16
) (
   input  logic [MAG_W-1:0] mag_i,
   input  logic [MAG_W-1:0] thr_i,
   output logic             good_o
);
   // Strict compare: equality counts as bad.
   assign good_o = (mag_i < thr_i);
endmodule

// File: rtl/lockdet_run_ctr.sv
module lockdet_run_ctr #(
   parameter int CNT_W = 21,
   parameter int EXP_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             clr_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   if (CNT_W < 2) begin : g_bad_w
      $error("lockdet_run_ctr: CNT_W must be at least 2");
   end

   assign target = CNT_W'(1) << exp_i;
   assign done_o = step_i && (cnt_q >= target - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (done_o)      cnt_q <= '0;
      else if (clr_i)       cnt_q <= '0;
      else if (step_i)      cnt_q <= cnt_q + CNT_W'(1);
   end

   // R3
   clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !step_i) |=> (cnt_q == '0));

   // R8
   done_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (cnt_q == '0));

   // R9
   idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det
   import lockdet_pkg::*;
#(
   parameter int MAG_W = 16,
   parameter int XW    = 5,
   parameter int YW    = 3,
   parameter int X_MAX = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_vld_i,
   input  logic [MAG_W-1:0] smp_mag_i,
   input  logic [MAG_W-1:0] thr_i,
   input  logic [XW-1:0]    lock_exp_i,
   input  logic [YW-1:0]    unlock_exp_i,
   output logic             locked_o
);
   localparam int LCNT_W = X_MAX + 1;
   localparam int UEXP_W = YW + 1;
   localparam int UCNT_W = (1 << YW) + 1;
   localparam int X_CEIL = (1 << XW) - 1;

   if (X_MAX < 1 || X_MAX > 30) begin : g_bad_xmax
      $error("phase_lock_det: X_MAX out of range");
   end
   if (YW < 1 || YW > 4) begin : g_bad_yw
      $error("phase_lock_det: YW out of range");
   end

   logic              good;
   logic              lock_q;
   logic [XW-1:0]     x_eff;
   logic [UEXP_W-1:0] y_eff;
   logic              lk_step, lk_clr, lk_done;
   logic              ul_step, ul_clr, ul_done;

   lockdet_cmp #(.MAG_W(MAG_W)) u_cmp (
      .mag_i  (smp_mag_i),
      .thr_i  (thr_i),
      .good_o (good)
   );

   // Clamp only when the exponent port can exceed the supported limit.
   if (X_MAX >= X_CEIL) begin : g_x_direct
      assign x_eff = lock_exp_i;
   end else begin : g_x_clamp
      assign x_eff = XW'(clamp_exp(int'(lock_exp_i), X_MAX));
   end

   assign y_eff = UEXP_W'(unlock_exp_i) + UEXP_W'(1);

   assign lk_step = smp_vld_i && good && !lock_q;
   assign lk_clr  = lock_q || (smp_vld_i && !good);
   assign ul_step = smp_vld_i && !good && lock_q;
   assign ul_clr  = !lock_q || (smp_vld_i && good);

   lockdet_run_ctr #(.CNT_W(LCNT_W), .EXP_W(XW)) u_lock_run (
      .clk    (clk),
      .rst    (rst),
      .step_i (lk_step),
      .clr_i  (lk_clr),
      .exp_i  (x_eff),
      .done_o (lk_done)
   );

   lockdet_run_ctr #(.CNT_W(UCNT_W), .EXP_W(UEXP_W)) u_unlock_run (
      .clk    (clk),
      .rst    (rst),
      .step_i (ul_step),
      .clr_i  (ul_clr),
      .exp_i  (y_eff),
      .done_o (ul_done)
   );

   always_ff @(posedge clk) begin
      if (rst)          lock_q <= 1'b0;
      else if (lk_done) lock_q <= 1'b1;
      else if (ul_done) lock_q <= 1'b0;
   end

   assign locked_o = lock_q;

   // R2
   lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked_o) |-> $past(smp_vld_i && good));

   // R6
   lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(locked_o) |-> $past(smp_vld_i && !good));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_vld_i |=> $stable(locked_o));

   // R10
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> !locked_o);

   // R4
   exp_limit_chk: assert property (@(posedge clk) disable iff (rst)
      int'(x_eff) <= X_MAX);
endmodule

// File: tb/tb_phase_lock_det.sv
`timescale 1ns/1ps
module tb_phase_lock_det;
   localparam int MAG_W = 16;
   localparam int XW    = 5;
   localparam int YW    = 3;
   localparam int X_MAX = 12;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             vld = 1'b0;
   logic [MAG_W-1:0] mag = '0;
   logic [MAG_W-1:0] thr = 16'd100;
   logic [XW-1:0]    xe  = '0;
   logic [YW-1:0]    ye  = '0;
   logic             locked;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   phase_lock_det #(.MAG_W(MAG_W), .XW(XW), .YW(YW), .X_MAX(X_MAX)) dut (
      .clk          (clk),
      .rst          (rst),
      .smp_vld_i    (vld),
      .smp_mag_i    (mag),
      .thr_i        (thr),
      .lock_exp_i   (xe),
      .unlock_exp_i (ye),
      .locked_o     (locked)
   );

   task automatic chk(input string req, input logic exp_v);
      checks++;
      if (locked !== exp_v) begin
         errors++;
         $display("FAIL %s: locked=%b expected=%b at %0t", req, locked, exp_v, $time);
      end
   endtask

   // One cycle of input; returns shortly after the edge.
   task automatic cyc(input logic v, input logic [MAG_W-1:0] m, input logic r);
      @(negedge clk);
      vld = v; mag = m; rst = r;
      @(posedge clk);
      #1;
      vld = 1'b0; rst = 1'b0;
   endtask

   task automatic run(input int n, input logic [MAG_W-1:0] m);
      for (int i = 0; i < n; i++) cyc(1'b1, m, 1'b0);
   endtask

   task automatic do_reset();
      cyc(1'b0, '0, 1'b1);
      cyc(1'b0, '0, 1'b1);
      chk("R10 reset state", 1'b0);
   endtask

   task automatic t_threshold();
      do_reset();
      xe = 5'd0; ye = 3'd0;
      run(1, 16'd100);
      chk("R1 equal is bad", 1'b0);
      run(1, 16'd99);
      chk("R11 single good sample locks", 1'b1);
   endtask

   task automatic t_lock_unlock();
      do_reset();
      xe = 5'd3; ye = 3'd1;
      run(7, 16'd5);
      chk("R2 not locked at 7", 1'b0);
      run(1, 16'd5);
      chk("R2 locked at 8", 1'b1);
      run(3, 16'd500);
      chk("R5 short bad run keeps lock", 1'b1);
      run(1, 16'd5);
      run(3, 16'd500);
      chk("R7 good sample restarts unlock run", 1'b1);
      run(1, 16'd500);
      chk("R6 unlock at 4 bad", 1'b0);
      run(7, 16'd5);
      chk("R8 requalify not done at 7", 1'b0);
      run(1, 16'd5);
      chk("R8 requalified at 8", 1'b1);
   endtask

   task automatic t_break();
      do_reset();
      xe = 5'd2; ye = 3'd0;
      run(3, 16'd5);
      run(1, 16'd100);
      run(3, 16'd5);
      chk("R3 bad sample discards run", 1'b0);
      run(1, 16'd5);
      chk("R3 full new run locks", 1'b1);
   endtask

   task automatic t_idle();
      do_reset();
      xe = 5'd2; ye = 3'd0;
      run(2, 16'd5);
      for (int i = 0; i < 3; i++) cyc(1'b0, 16'd900, 1'b0);
      run(1, 16'd5);
      chk("R9 idle neither breaks nor counts", 1'b0);
      run(1, 16'd5);
      chk("R9 lock after 4 valid good", 1'b1);
      for (int i = 0; i < 20; i++) cyc(1'b0, 16'd900, 1'b0);
      chk("R5 idle keeps lock", 1'b1);
      run(1, 16'd900);
      chk("R9 idle bad inputs ignored", 1'b1);
      run(1, 16'd900);
      chk("R6 Y=0 unlock at 2 bad", 1'b0);
   endtask

   task automatic t_reset_race();
      do_reset();
      xe = 5'd1; ye = 3'd0;
      run(1, 16'd5);
      cyc(1'b1, 16'd5, 1'b1);
      chk("R10 reset wins over completing sample", 1'b0);
      run(1, 16'd5);
      chk("R10 run cleared by reset", 1'b0);
      run(1, 16'd5);
      chk("R10 lock after fresh run", 1'b1);
   endtask

   task automatic t_clamp();
      do_reset();
      xe = 5'd31; ye = 3'd7;
      run((1 << X_MAX) - 1, 16'd5);
      chk("R4 clamped exponent not yet", 1'b0);
      run(1, 16'd5);
      chk("R4 clamped exponent locks", 1'b1);
      run(255, 16'd700);
      chk("R5 Y=7 holds at 255 bad", 1'b1);
      run(1, 16'd700);
      chk("R6 Y=7 unlock at 256 bad", 1'b0);
   endtask

   initial begin
      t_threshold();
      t_lock_unlock();
      t_break();
      t_idle();
      t_reset_race();
      t_clamp();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: locked=%b expected=done", locked);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule